// File: doc/BRIEF.md
# Two-Port Processor Mailbox

A single-clock message slot shared by two processors. One memory-mapped agent port belongs to the producing processor (the sender port), the other to the consuming processor (the receiver port). The slot holds one message of two data words: a command word and a pointer word. The sender fills the pointer word first, then writes the command word, which marks the slot occupied and can raise a level interrupt towards the receiver. The receiver reads the pointer word, then the command word; the command-word read frees the slot and can raise a level interrupt towards the sender.

While the slot is occupied, a sender write to either message word is held off with a wait-request until the receiver has taken the message, so a message is never overwritten. Only the sender port can mark the slot occupied and only the receiver port can free it. Each side owns one bit of a shared interrupt-enable register and gates its own interrupt with it.

Top module: `mbox_duplex`

## Requirements
- R1: After reset the slot is empty, both enable bits are 0, both interrupts are low, the sender wait-request is low and the status word reads 2.
- R2: A sender write to word address 0 while the slot is empty stores the command word and marks the slot occupied; the status word then reads 1.
- R3: While the slot is occupied, a sender write to address 0 or 1 drives wait-request high and changes neither message word; the write completes on the first clock after the receiver has freed the slot.
- R4: A receiver read of address 0 returns the command word and frees the slot; a receiver read of address 1 returns the pointer word and leaves the slot state unchanged.
- R5: The status word at address 2 has bit 0 set when occupied, bit 1 set when empty, and all other bits zero.
- R6: The receiver interrupt is high exactly while the slot is occupied and enable bit 0 is 1; it stays high until the receiver reads address 0.
- R7: The sender interrupt is high exactly while the slot is empty and enable bit 1 is 1.
- R8: The enable register at address 3 takes bit 0 only from receiver writes and bit 1 only from sender writes; both ports read it as a word with bit 1 and bit 0 in those places and zeros above.
- R9: Receiver writes to addresses 0, 1 and 2 and sender writes to address 2 have no effect.
- R10: Both ports return read data on the clock after the read is presented; addresses above 3 read as zero.
- R11: A sender write to address 1 while the slot is empty completes without wait-request and does not change the slot state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for the whole block |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_addr | input | ADDR_W | Sender port word address |
| snd_wr | input | 1 | Sender port write strobe |
| snd_rd | input | 1 | Sender port read strobe |
| snd_wdata | input | DATA_W | Sender port write data |
| snd_rdata | output | DATA_W | Sender port read data, one cycle after the read |
| snd_wait | output | 1 | Sender wait-request, high while a message-word write is held off |
| rcv_addr | input | ADDR_W | Receiver port word address |
| rcv_wr | input | 1 | Receiver port write strobe |
| rcv_rd | input | 1 | Receiver port read strobe |
| rcv_wdata | input | DATA_W | Receiver port write data |
| rcv_rdata | output | DATA_W | Receiver port read data, one cycle after the read |
| irq_rcv | output | 1 | Level interrupt to the receiver: message waiting |
| irq_snd | output | 1 | Level interrupt to the sender: slot free |

## Verification
The message path is driven with three patterns: a sender write into an empty slot, a second command write issued while the slot is still occupied, and receiver reads of the pointer word before the command word. The first shows that storing and flagging happen together, the second separates a correct stall from an overwrite or a lost write because the held-off write must land exactly after the freeing read, and the third tells a non-consuming pointer read apart from the consuming command read. Enable-register writes from the wrong port, writes to read-only words and out-of-map reads are mixed in so that an ignored access is distinguishable from one that leaks into state seen at the ports.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   // word addresses of the register map
   localparam int unsigned CMD_IDX  = 0;
   localparam int unsigned PTR_IDX  = 1;
   localparam int unsigned STAT_IDX = 2;
   localparam int unsigned MASK_IDX = 3;
   localparam int unsigned MAP_WORDS = 4;

   // status word bit positions
   localparam int unsigned ST_FULL_BIT  = 0;
   localparam int unsigned ST_EMPTY_BIT = 1;

   // enable register bit positions
   localparam int unsigned EN_PEND_BIT  = 0;
   localparam int unsigned EN_SPACE_BIT = 1;
   localparam int unsigned EN_W         = 2;
endpackage

// File: rtl/mbox_slot.sv
module mbox_slot #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_cmd,
   input  logic              load_ptr,
   input  logic              consume,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] cmd_word,
   output logic [DATA_W-1:0] ptr_word,
   output logic              full
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_word <= '0;
         ptr_word <= '0;
         full     <= 1'b0;
      end else begin
         if (load_cmd) begin
            cmd_word <= wdata;
            full     <= 1'b1;
         end else if (consume) begin
            full     <= 1'b0;
         end
         if (load_ptr) ptr_word <= wdata;
      end
   end
endmodule

// File: rtl/mbox_enable.sv
module mbox_enable
   import mbox_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            snd_we,
   input  logic            snd_bit,
   input  logic            rcv_we,
   input  logic            rcv_bit,
   input  logic            full,
   output logic [EN_W-1:0] en_q,
   output logic            irq_rcv,
   output logic            irq_snd
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
      end else begin
         if (rcv_we) en_q[EN_PEND_BIT]  <= rcv_bit;
         if (snd_we) en_q[EN_SPACE_BIT] <= snd_bit;
      end
   end

   assign irq_rcv = full  & en_q[EN_PEND_BIT];
   assign irq_snd = ~full & en_q[EN_SPACE_BIT];
endmodule

// File: rtl/mbox_rdport.sv
module mbox_rdport
   import mbox_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 3,
   parameter bit          CLEAR_IDLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] cmd_word,
   input  logic [DATA_W-1:0] ptr_word,
   input  logic              full,
   input  logic [EN_W-1:0]   en_q,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned PAD_W = DATA_W - EN_W;

   logic [DATA_W-1:0] sel;
   logic [EN_W-1:0]   stat;

   always_comb begin
      stat               = '0;
      stat[ST_FULL_BIT]  = full;
      stat[ST_EMPTY_BIT] = ~full;
      case (addr)
         ADDR_W'(CMD_IDX):  sel = cmd_word;
         ADDR_W'(PTR_IDX):  sel = ptr_word;
         ADDR_W'(STAT_IDX): sel = {{PAD_W{1'b0}}, stat};
         ADDR_W'(MASK_IDX): sel = {{PAD_W{1'b0}}, en_q};
         default:           sel = '0;
      endcase
   end

   generate
      if (CLEAR_IDLE) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd ? sel : '0;
         end
      end else begin : g_hold
         always_ff @(posedge clk) begin
            if (!rst_n)  rdata <= '0;
            else if (rd) rdata <= sel;
         end
      end
   endgenerate
endmodule

// File: rtl/mbox_duplex.sv
module mbox_duplex
   import mbox_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 3,
   parameter bit          CLEAR_IDLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] snd_addr,
   input  logic              snd_wr,
   input  logic              snd_rd,
   input  logic [DATA_W-1:0] snd_wdata,
   output logic [DATA_W-1:0] snd_rdata,
   output logic              snd_wait,
   input  logic [ADDR_W-1:0] rcv_addr,
   input  logic              rcv_wr,
   input  logic              rcv_rd,
   input  logic [DATA_W-1:0] rcv_wdata,
   output logic [DATA_W-1:0] rcv_rdata,
   output logic              irq_rcv,
   output logic              irq_snd
);
   localparam int unsigned MIN_ADDR_W = $clog2(MAP_WORDS);

   generate
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("mbox_duplex: ADDR_W too small for the register map");
      end
      if (DATA_W < EN_W) begin : g_bad_data
         $error("mbox_duplex: DATA_W narrower than the status word");
      end
   endgenerate

   logic              msg_full;
   logic [DATA_W-1:0] cmd_word;
   logic [DATA_W-1:0] ptr_word;
   logic [EN_W-1:0]   en_q;

   logic snd_hit_cmd, snd_hit_ptr, snd_hit_en, rcv_hit_cmd, rcv_hit_en;
   logic snd_msg_wr, load_cmd, load_ptr, consume;
   logic unused_rcv_bits;

   assign snd_hit_cmd = snd_addr == ADDR_W'(CMD_IDX);
   assign snd_hit_ptr = snd_addr == ADDR_W'(PTR_IDX);
   assign snd_hit_en  = snd_addr == ADDR_W'(MASK_IDX);
   assign rcv_hit_cmd = rcv_addr == ADDR_W'(CMD_IDX);
   assign rcv_hit_en  = rcv_addr == ADDR_W'(MASK_IDX);

   assign snd_msg_wr = snd_wr & (snd_hit_cmd | snd_hit_ptr);
   assign snd_wait   = snd_msg_wr & msg_full;
   assign load_cmd   = snd_wr & snd_hit_cmd & ~msg_full;
   assign load_ptr   = snd_wr & snd_hit_ptr & ~msg_full;
   assign consume    = rcv_rd & rcv_hit_cmd & msg_full;

   assign unused_rcv_bits = ^rcv_wdata[DATA_W-1:1];

   mbox_slot #(.DATA_W(DATA_W)) slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_cmd (load_cmd),
      .load_ptr (load_ptr),
      .consume  (consume),
      .wdata    (snd_wdata),
      .cmd_word (cmd_word),
      .ptr_word (ptr_word),
      .full     (msg_full)
   );

   mbox_enable enable_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .snd_we  (snd_wr & snd_hit_en),
      .snd_bit (snd_wdata[EN_SPACE_BIT]),
      .rcv_we  (rcv_wr & rcv_hit_en),
      .rcv_bit (rcv_wdata[EN_PEND_BIT]),
      .full    (msg_full),
      .en_q    (en_q),
      .irq_rcv (irq_rcv),
      .irq_snd (irq_snd)
   );

   mbox_rdport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLEAR_IDLE(CLEAR_IDLE)) snd_rd_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd       (snd_rd),
      .addr     (snd_addr),
      .cmd_word (cmd_word),
      .ptr_word (ptr_word),
      .full     (msg_full),
      .en_q     (en_q),
      .rdata    (snd_rdata)
   );

   mbox_rdport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLEAR_IDLE(CLEAR_IDLE)) rcv_rd_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd       (rcv_rd),
      .addr     (rcv_addr),
      .cmd_word (cmd_word),
      .ptr_word (ptr_word),
      .full     (msg_full),
      .en_q     (en_q),
      .rdata    (rcv_rdata)
   );
endmodule

// File: rtl/mbox_duplex_chk.sv
module mbox_duplex_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] snd_addr,
   input logic              snd_wr,
   input logic              snd_wait,
   input logic [ADDR_W-1:0] rcv_addr,
   input logic              rcv_rd,
   input logic              rcv_wr,
   input logic              msg_full,
   input logic [DATA_W-1:0] cmd_word,
   input logic [DATA_W-1:0] ptr_word,
   input logic [1:0]        en_q,
   input logic              irq_rcv,
   input logic              irq_snd
);
   p_set_on_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_wr && snd_addr == ADDR_W'(0) && !snd_wait) |=> msg_full);

   p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_full && snd_wr && (snd_addr == ADDR_W'(0) || snd_addr == ADDR_W'(1))) |-> snd_wait);

   p_no_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
      msg_full |=> ($stable(cmd_word) && $stable(ptr_word)));

   p_consume_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rcv_rd && rcv_addr == ADDR_W'(0) && msg_full) |=> !msg_full);

   p_irq_rcv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rcv |-> (msg_full && en_q[0]));

   p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_rcv && !(rcv_rd && rcv_addr == ADDR_W'(0)) && !rcv_wr) |=> irq_rcv);

   p_irq_snd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_snd |-> (!msg_full && en_q[1]));

   p_only_snd_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_full) |-> $past(snd_wr && snd_addr == ADDR_W'(0)));

   p_only_rcv_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(msg_full) |-> $past(rcv_rd && rcv_addr == ADDR_W'(0)));

   p_en_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(snd_wr && snd_addr == ADDR_W'(3)) |=> $stable(en_q[1]));
endmodule

bind mbox_duplex mbox_duplex_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .snd_addr (snd_addr),
   .snd_wr   (snd_wr),
   .snd_wait (snd_wait),
   .rcv_addr (rcv_addr),
   .rcv_rd   (rcv_rd),
   .rcv_wr   (rcv_wr),
   .msg_full (msg_full),
   .cmd_word (cmd_word),
   .ptr_word (ptr_word),
   .en_q     (en_q),
   .irq_rcv  (irq_rcv),
   .irq_snd  (irq_snd)
);

// File: tb/mbox_duplex_tb_top.sv
`timescale 1ns/1ps
module mbox_duplex_tb_top;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] snd_addr = '0;
   logic          snd_wr = 1'b0;
   logic          snd_rd = 1'b0;
   logic [DW-1:0] snd_wdata = '0;
   logic [DW-1:0] snd_rdata;
   logic          snd_wait;
   logic [AW-1:0] rcv_addr = '0;
   logic          rcv_wr = 1'b0;
   logic          rcv_rd = 1'b0;
   logic [DW-1:0] rcv_wdata = '0;
   logic [DW-1:0] rcv_rdata;
   logic          irq_rcv;
   logic          irq_snd;

   int checks = 0;
   int errors = 0;

   logic [DW-1:0] snd_exp_q[$];
   string         snd_tag_q[$];
   logic [DW-1:0] rcv_exp_q[$];
   string         rcv_tag_q[$];
   logic          snd_seen = 1'b0;
   logic          rcv_seen = 1'b0;

   always #4 clk = ~clk;

   mbox_duplex #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .snd_addr(snd_addr), .snd_wr(snd_wr), .snd_rd(snd_rd),
      .snd_wdata(snd_wdata), .snd_rdata(snd_rdata), .snd_wait(snd_wait),
      .rcv_addr(rcv_addr), .rcv_wr(rcv_wr), .rcv_rd(rcv_rd),
      .rcv_wdata(rcv_wdata), .rcv_rdata(rcv_rdata),
      .irq_rcv(irq_rcv), .irq_snd(irq_snd)
   );

   task automatic check(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // monitor: read data is valid at the falling edge after the capturing edge
   always @(posedge clk) begin
      snd_seen <= snd_rd;
      rcv_seen <= rcv_rd;
   end

   initial begin
      forever begin
         @(negedge clk);
         if (snd_seen) begin
            if (snd_exp_q.size() == 0) check(1, 0, "R10 unexpected sender read");
            else check(snd_rdata, snd_exp_q.pop_front(), snd_tag_q.pop_front());
         end
         if (rcv_seen) begin
            if (rcv_exp_q.size() == 0) check(1, 0, "R10 unexpected receiver read");
            else check(rcv_rdata, rcv_exp_q.pop_front(), rcv_tag_q.pop_front());
         end
      end
   end

   // drivers
   task automatic snd_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      snd_addr = a; snd_wdata = d; snd_wr = 1'b1;
      #1;
      while (snd_wait) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      snd_wr = 1'b0;
   endtask

   task automatic rcv_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      rcv_addr = a; rcv_wdata = d; rcv_wr = 1'b1;
      @(negedge clk);
      rcv_wr = 1'b0;
   endtask

   task automatic snd_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
      @(negedge clk);
      snd_addr = a; snd_rd = 1'b1;
      snd_exp_q.push_back(exp); snd_tag_q.push_back(tag);
      @(negedge clk);
      snd_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic rcv_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
      @(negedge clk);
      rcv_addr = a; rcv_rd = 1'b1;
      rcv_exp_q.push_back(exp); rcv_tag_q.push_back(tag);
      @(negedge clk);
      rcv_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic run_tests();
      logic [DW-1:0] c1 = 32'hC0DE_0001;
      logic [DW-1:0] c2 = 32'hC0DE_0002;
      logic [DW-1:0] p1 = 32'h1000_4000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(irq_rcv, 0, "R1 irq_rcv after reset");
      check(irq_snd, 0, "R1 irq_snd after reset");
      check(snd_wait, 0, "R1 wait after reset");
      rcv_read(2, 32'd2, "R1 status empty after reset");
      snd_read(3, 32'd0, "R1 enables clear after reset");

      // pointer write on empty slot
      snd_write(1, p1);
      rcv_read(2, 32'd2, "R11 pointer write leaves slot empty");
      // command write
      snd_write(0, c1);
      rcv_read(2, 32'd1, "R2 status full after command");
      snd_read(0, c1, "R2 command word stored");
      check(irq_rcv, 0, "R6 irq_rcv masked");
      rcv_write(3, 32'h1);
      check(irq_rcv, 1, "R6 irq_rcv enabled while full");
      snd_read(3, 32'h1, "R8 enable bit0 from receiver");

      // held-off second command
      fork
         snd_write(0, c2);
         begin
            repeat (2) @(negedge clk);
            #1;
            check(snd_wait, 1, "R3 wait while occupied");
            rcv_read(1, p1, "R3 pointer kept during stall");
            check(snd_wait, 1, "R3 wait holds across pointer read");
            rcv_read(0, c1, "R4 first command returned");
         end
      join
      check(irq_rcv, 1, "R6 irq_rcv for second message");
      rcv_read(2, 32'd1, "R3 stalled write landed");

      // pointer read does not consume, command read does
      rcv_read(1, p1, "R4 pointer read");
      rcv_read(2, 32'd1, "R4 pointer read keeps full");
      check(irq_rcv, 1, "R6 level held until command read");
      rcv_read(0, c2, "R4 second command returned");
      rcv_read(2, 32'd2, "R5 status empty after consume");
      check(irq_rcv, 0, "R6 irq_rcv low after consume");

      // sender interrupt and enable ownership
      check(irq_snd, 0, "R7 irq_snd masked");
      snd_write(3, 32'h2);
      check(irq_snd, 1, "R7 irq_snd enabled while empty");
      snd_read(3, 32'h3, "R8 both enables set");
      rcv_write(3, 32'h2);
      rcv_read(3, 32'h2, "R8 receiver write leaves bit1");
      snd_write(3, 32'h1);
      rcv_read(3, 32'h0, "R8 sender write leaves bit0");
      check(irq_snd, 0, "R7 irq_snd disabled");
      snd_write(3, 32'h2);
      rcv_write(3, 32'h1);

      // ignored writes
      rcv_write(0, 32'hDEAD_0000);
      rcv_write(1, 32'hBEEF_0000);
      rcv_write(2, 32'h1);
      snd_write(2, 32'h1);
      rcv_read(2, 32'd2, "R9 status unaffected by writes");
      snd_read(1, p1, "R9 pointer unaffected by receiver");
      snd_read(0, c2, "R9 command unaffected by receiver");
      check(irq_snd, 1, "R9 irq_snd still high");

      // both interrupts swap on a new message
      snd_write(0, c1);
      check(irq_snd, 0, "R7 irq_snd low when full");
      check(irq_rcv, 1, "R6 irq_rcv high when full");

      // unmapped addresses
      rcv_read(5, 32'd0, "R10 unmapped receiver read");
      snd_read(7, 32'd0, "R10 unmapped sender read");
      rcv_read(0, c1, "R10 read latency one cycle");
      repeat (2) @(negedge clk);
      check(snd_exp_q.size() + rcv_exp_q.size(), 0, "R10 all reads answered");
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule